// File: doc/BRIEF.md
# Two-Sided Channel Handshake Semaphore

This block holds a small array of per-channel handshake states shared by two processors. One processor starts transactions (the requester side) and the other serves them (the responder side). Each channel carries a two-bit state that moves through a fixed four-phase cycle. The cycle runs from free to request posted, then request taken, then response ready, and back to free.

Neither side ever writes a state value directly. Each side has its own register port. On that port it can read a shared status word. It can also write a set word that turns on the status bits marked with ones, or a clear word that turns off the status bits marked with ones. Every write takes effect in one clock. Bits written as zero are left as they are. When a set and a clear hit the same bit in the same cycle, the clear wins. Two level outputs tell each side when a channel is waiting for it.

Top module: `chan_handshake_sema`

## Requirements
- R1: After reset, every channel is in state 2 (free), and both interrupt outputs are low.
- R2: In the status word, read at byte offset 0x0, channel n sits at bits [2n+1:2n]. Bits above the last channel read as 0. Both ports read the same status word.
- R3: A write at offset 0x4 (set word) turns on every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R4: A write at offset 0x8 (clear word) turns off every status bit whose write-data bit is 1. Other status bits keep their value.
- R5: When a set and a clear on the two ports hit the same bit in the same cycle, the bit ends at 0. Set words on both ports combine by OR, and so do clear words on both ports.
- R6: The handshake sequence works as follows. The requester clears both bits of a channel, giving state 0. The responder sets pattern 1, giving state 1. The responder then sets pattern 3, giving state 3. Finally the requester clears pattern 1, returning the channel to state 2.
- R7: Writes to offset 0x0 and to any offset other than 0x4 and 0x8 change nothing. Reads at any offset other than 0x0 return 0.
- R8: `irq_to_resp` is high exactly while some channel is in state 0.
- R9: `irq_to_req` is high exactly while some channel is in state 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| req_wr | input | 1 | Requester write strobe |
| req_addr | input | ADDR_W | Requester byte offset |
| req_wdata | input | 32 | Requester write data |
| req_rdata | output | 32 | Requester read data at req_addr (combinational) |
| rsp_wr | input | 1 | Responder write strobe |
| rsp_addr | input | ADDR_W | Responder byte offset |
| rsp_wdata | input | 32 | Responder write data |
| rsp_rdata | output | 32 | Responder read data at rsp_addr (combinational) |
| irq_to_req | output | 1 | Level: some channel holds a response |
| irq_to_resp | output | 1 | Level: some channel holds a request |

## Verification
On every cycle, the assertions check the following:
- Each channel's bits obey set-to-one, clear-to-zero and hold-when-unwritten.
- A clear beats a same-cycle set.
- Channels come out of reset free.
- The two read ports agree when they address the same offset.
- An interrupt only rises after a write.

Some behaviours only the bench's scenarios can show. These are the full four-phase handshake order, the exact status layout under random traffic from both ports, and the silence of undefined offsets. The bench also shows that each interrupt level matches the states held in the model.

// File: rtl/sema_pkg.sv
package sema_pkg;
  localparam int unsigned REG_W = 32;
  localparam logic [7:0] OFS_STATUS = 8'h00;
  localparam logic [7:0] OFS_SET    = 8'h04;
  localparam logic [7:0] OFS_CLR    = 8'h08;

  typedef enum logic [1:0] {
    CH_REQ    = 2'd0,
    CH_QUEUED = 2'd1,
    CH_FREE   = 2'd2,
    CH_RESP   = 2'd3
  } ch_state_e;
endpackage

// File: rtl/sema_rst_sync.sv
module sema_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/sema_port_dec.sv
module sema_port_dec
  import sema_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [STAT_W-1:0] status_i,
  output logic [STAT_W-1:0] set_o,
  output logic [STAT_W-1:0] clr_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic sel_status, sel_set, sel_clr;
  logic unused_wdata_hi;

  assign sel_status = (addr_i == ADDR_W'(OFS_STATUS));
  assign sel_set    = (addr_i == ADDR_W'(OFS_SET));
  assign sel_clr    = (addr_i == ADDR_W'(OFS_CLR));

  always_comb begin
    set_o = '0;
    clr_o = '0;
    if (wr_i && sel_set) set_o = wdata_i[STAT_W-1:0];
    if (wr_i && sel_clr) clr_o = wdata_i[STAT_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    if (sel_status) rdata_o[STAT_W-1:0] = status_i;
  end

  assign unused_wdata_hi = ^wdata_i;

  // R7: a single write never drives both the set and the clear mask
  p_one_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !((|set_o) && (|clr_o)));
endmodule

// File: rtl/sema_chan_cell.sv
module sema_chan_cell
  import sema_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] set_i,
  input  logic [1:0] clr_i,
  output logic [1:0] state_o
);
  logic [1:0] state_q, state_d;
  logic       state_en;

  assign state_en = (|set_i) | (|clr_i);

  always_comb begin
    state_d = (state_q | set_i) & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= CH_FREE;
    else if (state_en) state_q <= state_d;
  end

  assign state_o = state_q;

  p_set_applies_r3: assert property (@(posedge clk) disable iff (!rst_n)
    |(set_i & ~clr_i) |=> ((state_o & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));
  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    |clr_i |=> ((state_o & $past(clr_i)) == 2'b00));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i | clr_i) == 2'b00) |=> $stable(state_o));
  p_reset_free_r1: assert property (@(posedge clk)
    (rst_n && !$past(rst_n)) |-> (state_o == CH_FREE));
endmodule

// File: rtl/sema_irq.sv
module sema_irq
  import sema_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic [2*NUM_CH-1:0] status_i,
  output logic                req_pending_o,
  output logic                resp_pending_o
);
  logic [NUM_CH-1:0] is_req, is_resp;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign is_req[c]  = (status_i[2*c +: 2] == CH_REQ);
    assign is_resp[c] = (status_i[2*c +: 2] == CH_RESP);
  end

  assign req_pending_o  = |is_req;
  assign resp_pending_o = |is_resp;
endmodule

// File: rtl/chan_handshake_sema.sv
module chan_handshake_sema
  import sema_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       req_rdata,
  input  logic              rsp_wr,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic [31:0]       rsp_wdata,
  output logic [31:0]       rsp_rdata,
  output logic              irq_to_req,
  output logic              irq_to_resp
);
  localparam int unsigned STAT_W = 2 * NUM_CH;

  logic              rst_n;
  logic [STAT_W-1:0] status;
  logic [STAT_W-1:0] req_set, req_clr, rsp_set, rsp_clr;
  logic [STAT_W-1:0] set_all, clr_all;

  sema_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n_o(rst_n));

  sema_port_dec #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_dec_req (
    .clk(clk), .rst_n(rst_n), .wr_i(req_wr), .addr_i(req_addr),
    .wdata_i(req_wdata), .status_i(status),
    .set_o(req_set), .clr_o(req_clr), .rdata_o(req_rdata));

  sema_port_dec #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_dec_rsp (
    .clk(clk), .rst_n(rst_n), .wr_i(rsp_wr), .addr_i(rsp_addr),
    .wdata_i(rsp_wdata), .status_i(status),
    .set_o(rsp_set), .clr_o(rsp_clr), .rdata_o(rsp_rdata));

  assign set_all = req_set | rsp_set;
  assign clr_all = req_clr | rsp_clr;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cell
    sema_chan_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_all[2*c +: 2]), .clr_i(clr_all[2*c +: 2]),
      .state_o(status[2*c +: 2]));
  end

  sema_irq #(.NUM_CH(NUM_CH)) u_irq (
    .status_i(status), .req_pending_o(irq_to_resp), .resp_pending_o(irq_to_req));

  p_read_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr == rsp_addr) |-> (req_rdata == rsp_rdata));
  p_resp_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_to_req) |-> $past(req_wr || rsp_wr));
  p_req_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_to_resp) |-> $past(req_wr || rsp_wr));
  p_reset_quiet_r1: assert property (@(posedge clk)
    (rst_n && !$past(rst_n)) |-> (!irq_to_req && !irq_to_resp));
endmodule

// File: tb/sim_chan_handshake_sema.sv
`timescale 1ns/1ps
module sim_chan_handshake_sema;
  localparam int NCH = 8;
  localparam int AW  = 4;
  localparam int SW  = 2 * NCH;

  logic clk = 1'b0;
  logic arst_n;
  logic req_wr, rsp_wr;
  logic [AW-1:0] req_addr, rsp_addr;
  logic [31:0] req_wdata, rsp_wdata, req_rdata, rsp_rdata;
  logic irq_to_req, irq_to_resp;

  int errors = 0;
  int checks = 0;
  logic [SW-1:0] model;

  always #2.5 clk = ~clk;

  chan_handshake_sema #(.NUM_CH(NCH), .ADDR_W(AW)) u0 (
    .clk(clk), .arst_n(arst_n),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata),
    .rsp_wr(rsp_wr), .rsp_addr(rsp_addr), .rsp_wdata(rsp_wdata), .rsp_rdata(rsp_rdata),
    .irq_to_req(irq_to_req), .irq_to_resp(irq_to_resp));

  function automatic logic [SW-1:0] masks_for(input logic wr, input logic [AW-1:0] a,
                                              input logic [31:0] d, input logic [7:0] ofs);
    return (wr && a == AW'(ofs)) ? d[SW-1:0] : '0;
  endfunction

  function automatic logic any_state(input logic [SW-1:0] s, input logic [1:0] v);
    logic hit = 1'b0;
    for (int c = 0; c < NCH; c++) if (s[2*c +: 2] == v) hit = 1'b1;
    return hit;
  endfunction

  task automatic expect32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    expect32({tag, " R2 status req port"}, req_rdata, {{(32-SW){1'b0}}, model});
    expect32({tag, " R2 status rsp port"}, rsp_rdata, {{(32-SW){1'b0}}, model});
    expect32({tag, " R8 irq_to_resp"}, {31'd0, irq_to_resp}, {31'd0, any_state(model, 2'd0)});
    expect32({tag, " R9 irq_to_req"}, {31'd0, irq_to_req}, {31'd0, any_state(model, 2'd3)});
  endtask

  task automatic cycle(input logic mw, input logic [AW-1:0] ma, input logic [31:0] md,
                       input logic sw, input logic [AW-1:0] sa, input logic [31:0] sd,
                       input string tag);
    logic [SW-1:0] s, c;
    @(negedge clk);
    req_wr = mw; req_addr = ma; req_wdata = md;
    rsp_wr = sw; rsp_addr = sa; rsp_wdata = sd;
    s = masks_for(mw, ma, md, 8'h04) | masks_for(sw, sa, sd, 8'h04);
    c = masks_for(mw, ma, md, 8'h08) | masks_for(sw, sa, sd, 8'h08);
    @(posedge clk);
    model = (model | s) & ~c;
    @(negedge clk);
    req_wr = 1'b0; rsp_wr = 1'b0; req_addr = '0; rsp_addr = '0;
    #0.5;
    check_all(tag);
  endtask

  initial begin
    #150000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    arst_n = 1'b0;
    req_wr = 0; rsp_wr = 0; req_addr = '0; rsp_addr = '0; req_wdata = '0; rsp_wdata = '0;
    model = '0;
    for (int c = 0; c < NCH; c++) model[2*c +: 2] = 2'd2;
    repeat (3) @(posedge clk);
    @(negedge clk); arst_n = 1'b1;
    repeat (3) @(negedge clk);
    #0.5;
    check_all("R1 reset");
    expect32("R1 status all free", req_rdata, 32'h0000_AAAA);

    // R6 handshake on channel 2 (bits [5:4])
    cycle(1, 4'h8, 32'h30, 0, 4'h0, 0, "R6 post request");
    expect32("R6 state 0", {30'd0, model[5:4]}, 32'd0);
    expect32("R6 dut ch2=0", {30'd0, req_rdata[5:4]}, 32'd0);
    cycle(0, 4'h0, 0, 1, 4'h4, 32'h10, "R6 take request");
    expect32("R6 dut ch2=1", {30'd0, rsp_rdata[5:4]}, 32'd1);
    cycle(0, 4'h0, 0, 1, 4'h4, 32'h30, "R6 post response");
    expect32("R6 dut ch2=3", {30'd0, req_rdata[5:4]}, 32'd3);
    cycle(1, 4'h8, 32'h10, 0, 4'h0, 0, "R6 ack response");
    expect32("R6 dut ch2=2", {30'd0, req_rdata[5:4]}, 32'd2);

    // R5 clear wins over a same-cycle set (channel 0)
    cycle(1, 4'h4, 32'h3, 1, 4'h8, 32'h3, "R5 clear beats set");
    expect32("R5 dut ch0=0", {30'd0, req_rdata[1:0]}, 32'd0);
    // R3 set leaves zero bits alone
    cycle(0, 4'h0, 0, 1, 4'h4, 32'h1, "R3 set low bit");
    // R4 clear leaves zero bits alone
    cycle(1, 4'h8, 32'h0000_4000, 0, 4'h0, 0, "R4 clear one bit");

    // R7 status and undefined offsets ignore writes; non-status reads are zero
    cycle(1, 4'h0, 32'hFFFF_FFFF, 1, 4'hC, 32'hFFFF_FFFF, "R7 ignored writes");
    cycle(1, 4'h2, 32'h0, 1, 4'hF, 32'hFFFF_FFFF, "R7 odd offsets");
    @(negedge clk); req_addr = 4'h4; rsp_addr = 4'h8; #0.5;
    expect32("R7 read set word", req_rdata, 32'd0);
    expect32("R7 read clr word", rsp_rdata, 32'd0);
    rsp_addr = 4'hC; #0.5;
    expect32("R7 read undefined", rsp_rdata, 32'd0);
    req_addr = '0; rsp_addr = '0;

    // Random traffic from both ports (R2 R3 R4 R5 R8 R9)
    for (int i = 0; i < 600; i++) begin
      logic [3:0] pick_m, pick_s;
      logic [AW-1:0] am, as;
      pick_m = 4'($urandom_range(0, 9));
      pick_s = 4'($urandom_range(0, 9));
      am = (pick_m < 4) ? 4'h4 : (pick_m < 8) ? 4'h8 : AW'($urandom);
      as = (pick_s < 4) ? 4'h4 : (pick_s < 8) ? 4'h8 : AW'($urandom);
      cycle(1'($urandom), am, $urandom & $urandom, 1'($urandom), as, $urandom & $urandom,
            "random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule